// File: doc/BRIEF.md
# Dual-Mode Fast/Slow Pulse-Width Generator

This block drives one PWM pin for a single output channel and offers two operating modes. In the fast mode it emits a pulse train whose period is `2^DUTY_W` clocks and whose high time equals the fast duty value. With the defaults and a 20 MHz clock that is a 1024-clock, roughly 19.5 kHz carrier, fit for smoothing into a DC level by an external RC stage.

The slow mode produces a roughly 200 Hz waveform. The base counter is slowed by a prescale of `2^PRESCALE_LOG2`, which is 16 by default and gives a base period of about 1.2 kHz. A slot counter then groups `FRAME_LEN` (six) base periods into one output frame. Leading slots are forced fully high. The single slot after them carries an ordinary PWM pulse set by a partial duty, and the remaining slots are forced fully low. A filter-enable pin is modelled as an output-enable/data pair. It pulls low in the fast mode, which connects the external smoothing capacitor. It floats in the slow mode, which disconnects the capacitor.

A small state machine sequences the slots. Its states are `ST_LOAD`, `ST_FAST`, `ST_SLOW_HIGH`, `ST_SLOW_PART` and `ST_SLOW_LOW`. The transitions are as follows:

- **load→fast / load→slow:** the single cycle after reset.
- **any→fast:** at every fast period end.
- **frame start:** at the last slot's end, going to HIGH, PART or LOW according to the clamped full count.
- **HIGH→HIGH/PART, PART→LOW, LOW→LOW:** at each base period end within a frame.

Top module: `dual_mode_pwm`

## Requirements
- R1: In fast mode the output repeats every `2^DUTY_W` clocks. It is high for exactly `fast_duty_i` clocks, starting at the beginning of the period, so there is one pulse per period.
- R2: In slow mode each base period lasts `2^(DUTY_W+PRESCALE_LOG2)` clocks, and a frame is `FRAME_LEN` base periods.
- R3: In slow mode a frame begins with `slow_full_i` fully high base periods. The next base period is high from its start for `slow_part_i * 2^PRESCALE_LOG2` clocks, and the rest of the frame is low, so there is one pulse per frame. A full count of `FRAME_LEN` or more makes the output high for the whole frame.
- R4: A duty of all ones (fast duty, or the slow partial duty) makes that period entirely high. A fast duty of all ones gives a constant high output, and a full count of `FRAME_LEN-1` with an all-ones partial duty gives a constant high slow output.
- R5: A fast duty of 0, or a slow setting of full count 0 with partial duty 0, gives a constant low output with no pulse.
- R6: Mode and duty inputs are sampled only at the first clock of a fast period or of a slow frame. A change made within a period does not alter that period's waveform.
- R7: The filter-enable pair reads oe=1, data=0 while the latched mode is fast, and oe=0 while it is slow. It follows the latched mode, not the live mode input.
- R8: During reset `pwm_o` and `filt_en_oe_o` are 0. The first period's output starts two clocks after reset is released: one load cycle, then one output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_mode_i | input | 1 | 1 selects slow mode, 0 selects fast mode |
| fast_duty_i | input | DUTY_W | Fast mode high time in clocks (all ones = constant high) |
| slow_full_i | input | SLOT_W | Count of fully high base periods per slow frame |
| slow_part_i | input | DUTY_W | Partial duty of the slot after the full-high ones |
| pwm_o | output | 1 | PWM output |
| filt_en_oe_o | output | 1 | Filter-enable pin driver enable (1 = driven) |
| filt_en_o | output | 1 | Filter-enable pin data, always 0 |

## Verification
The bench uses a reduced configuration: 4-bit duty, prescale 2 and a six-slot frame. It sweeps every fast duty from 0 to 15 and every slow full count from 0 to 7, each paired with partial duties 0, 1, 9 and 15. For each setting it counts high clocks and rising edges over whole periods or frames, compared against arithmetic totals. High counts catch errors in scaling, clamping and saturation. Edge counts show whether the full-high slots and the partial slot join into one pulse and whether the extreme values stay glitch free. Separate directed runs change the duty and the mode partway through a period. Comparing the current and the following period tells the latched behaviour apart from an immediate update. A reset-release run checks the two-cycle start latency.

// File: rtl/dmpwm_pkg.sv
package dmpwm_pkg;

    typedef enum logic [2:0] {
        ST_LOAD      = 3'd0,
        ST_FAST      = 3'd1,
        ST_SLOW_HIGH = 3'd2,
        ST_SLOW_PART = 3'd3,
        ST_SLOW_LOW  = 3'd4
    } stage_t;

endpackage

// File: rtl/dmpwm_timebase.sv
module dmpwm_timebase #(
    parameter int DUTY_W        = 10,
    parameter int PRESCALE_LOG2 = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_i,
    input  logic              slow_i,
    output logic [DUTY_W-1:0] phase_o,
    output logic              last_o
);

    logic [DUTY_W-1:0] phase_q;
    logic              tick;

    generate
        if (PRESCALE_LOG2 > 0) begin : g_prescale
            logic [PRESCALE_LOG2-1:0] pre_q;

            always_ff @(posedge clk) begin
                if (rst || !run_i) begin
                    pre_q <= '0;
                end else if (slow_i) begin
                    pre_q <= pre_q + 1'b1;
                end else begin
                    pre_q <= '0;
                end
            end

            assign tick = !slow_i || (pre_q == '1);
        end else begin : g_no_prescale
            assign tick = 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            phase_q <= '0;
        end else if (tick) begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assign phase_o = phase_q;
    assign last_o  = run_i && tick && (phase_q == '1);

    assert_wrap_after_last_R1: assert property (@(posedge clk) disable iff (rst)
        last_o |=> (phase_q == '0));

    assert_fast_step_R1: assert property (@(posedge clk) disable iff (rst)
        (run_i && !slow_i && !last_o) |=> (phase_q == DUTY_W'($past(phase_q) + 1'b1)));

endmodule

// File: rtl/dmpwm_sequencer.sv
module dmpwm_sequencer
    import dmpwm_pkg::*;
#(
    parameter int DUTY_W    = 10,
    parameter int FRAME_LEN = 6,
    parameter int SLOT_W    = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              period_last_i,
    input  logic              slow_mode_i,
    input  logic [DUTY_W-1:0] fast_duty_i,
    input  logic [SLOT_W-1:0] slow_full_i,
    input  logic [DUTY_W-1:0] slow_part_i,
    output stage_t            stage_o,
    output logic              slow_q_o,
    output logic [DUTY_W-1:0] duty_o
);

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(FRAME_LEN - 1);
    localparam logic [SLOT_W-1:0] FULL_MAX  = SLOT_W'(FRAME_LEN);

    stage_t            stage_q, stage_d;
    logic [SLOT_W-1:0] slot_q, slot_d;
    logic              slow_q;
    logic [DUTY_W-1:0] fduty_q, part_q;
    logic [SLOT_W-1:0] full_q;
    logic [SLOT_W-1:0] full_in_clamped;
    logic              frame_start;

    function automatic stage_t slot_stage(input logic [SLOT_W-1:0] slot,
                                          input logic [SLOT_W-1:0] full);
        if (slot < full)       return ST_SLOW_HIGH;
        else if (slot == full) return ST_SLOW_PART;
        else                   return ST_SLOW_LOW;
    endfunction

    assign full_in_clamped = (slow_full_i > FULL_MAX) ? FULL_MAX : slow_full_i;
    assign frame_start = (stage_q == ST_LOAD) ||
                         (period_last_i && (!slow_q || (slot_q == LAST_SLOT)));

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= ST_LOAD;
            slot_q  <= '0;
        end else begin
            stage_q <= stage_d;
            slot_q  <= slot_d;
        end
    end

    // input latches, loaded only at a frame boundary
    always_ff @(posedge clk) begin
        if (rst) begin
            slow_q  <= 1'b0;
            fduty_q <= '0;
            full_q  <= '0;
            part_q  <= '0;
        end else if (frame_start) begin
            slow_q  <= slow_mode_i;
            fduty_q <= fast_duty_i;
            full_q  <= full_in_clamped;
            part_q  <= slow_part_i;
        end
    end

    // next-state logic
    always_comb begin
        stage_d = stage_q;
        slot_d  = slot_q;
        unique case (stage_q)
            ST_LOAD, ST_FAST, ST_SLOW_HIGH, ST_SLOW_PART, ST_SLOW_LOW: begin
                if (frame_start) begin
                    slot_d  = '0;
                    stage_d = slow_mode_i ? slot_stage('0, full_in_clamped) : ST_FAST;
                end else if (period_last_i) begin
                    slot_d  = slot_q + 1'b1;
                    stage_d = slot_stage(slot_q + 1'b1, full_q);
                end
            end
            default: begin
                stage_d = ST_LOAD;
                slot_d  = '0;
            end
        endcase
    end

    assign stage_o  = stage_q;
    assign slow_q_o = slow_q;
    assign duty_o   = (stage_q == ST_FAST) ? fduty_q : part_q;

    assert_slot_range_R2: assert property (@(posedge clk) disable iff (rst)
        slot_q <= LAST_SLOT);

    assert_latch_at_boundary_R6: assert property (@(posedge clk) disable iff (rst)
        !$stable(fduty_q) |-> $past(frame_start));

    assert_high_slot_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (stage_q == ST_SLOW_HIGH && !period_last_i) |=> (stage_q == ST_SLOW_HIGH));

    assert_load_once_R8: assert property (@(posedge clk) disable iff (rst)
        (stage_q == ST_LOAD) |=> (stage_q != ST_LOAD));

endmodule

// File: rtl/dmpwm_compare.sv
module dmpwm_compare
    import dmpwm_pkg::*;
#(
    parameter int DUTY_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  stage_t            stage_i,
    input  logic [DUTY_W-1:0] phase_i,
    input  logic [DUTY_W-1:0] duty_i,
    output logic              pwm_o
);

    logic pwm_d, pwm_q;

    always_comb begin
        pwm_d = 1'b0;
        unique case (stage_i)
            ST_SLOW_HIGH:          pwm_d = 1'b1;
            ST_FAST, ST_SLOW_PART: pwm_d = (duty_i == '1) || (phase_i < duty_i);
            ST_LOAD, ST_SLOW_LOW:  pwm_d = 1'b0;
            default:               pwm_d = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) pwm_q <= 1'b0;
        else     pwm_q <= pwm_d;
    end

    assign pwm_o = pwm_q;

    assert_high_slot_drives_R3: assert property (@(posedge clk) disable iff (rst)
        (stage_i == ST_SLOW_HIGH) |=> pwm_q);

    assert_zero_duty_low_R5: assert property (@(posedge clk) disable iff (rst)
        ((stage_i == ST_FAST || stage_i == ST_SLOW_PART) && duty_i == '0) |=> !pwm_q);

    assert_full_duty_high_R4: assert property (@(posedge clk) disable iff (rst)
        ((stage_i == ST_FAST || stage_i == ST_SLOW_PART) && duty_i == '1) |=> pwm_q);

endmodule

// File: rtl/dual_mode_pwm.sv
module dual_mode_pwm
    import dmpwm_pkg::*;
#(
    parameter int DUTY_W        = 10,
    parameter int PRESCALE_LOG2 = 4,
    parameter int FRAME_LEN     = 6,
    localparam int SLOT_W       = $clog2(FRAME_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              slow_mode_i,
    input  logic [DUTY_W-1:0] fast_duty_i,
    input  logic [SLOT_W-1:0] slow_full_i,
    input  logic [DUTY_W-1:0] slow_part_i,
    output logic              pwm_o,
    output logic              filt_en_oe_o,
    output logic              filt_en_o
);

    stage_t            stage;
    logic              slow_q;
    logic [DUTY_W-1:0] duty;
    logic [DUTY_W-1:0] phase;
    logic              period_last;
    logic              running;
    logic              oe_q;

    assign running = (stage != ST_LOAD);

    dmpwm_timebase #(
        .DUTY_W        (DUTY_W),
        .PRESCALE_LOG2 (PRESCALE_LOG2)
    ) u_timebase (
        .clk     (clk),
        .rst     (rst),
        .run_i   (running),
        .slow_i  (slow_q),
        .phase_o (phase),
        .last_o  (period_last)
    );

    dmpwm_sequencer #(
        .DUTY_W    (DUTY_W),
        .FRAME_LEN (FRAME_LEN),
        .SLOT_W    (SLOT_W)
    ) u_sequencer (
        .clk           (clk),
        .rst           (rst),
        .period_last_i (period_last),
        .slow_mode_i   (slow_mode_i),
        .fast_duty_i   (fast_duty_i),
        .slow_full_i   (slow_full_i),
        .slow_part_i   (slow_part_i),
        .stage_o       (stage),
        .slow_q_o      (slow_q),
        .duty_o        (duty)
    );

    dmpwm_compare #(
        .DUTY_W (DUTY_W)
    ) u_compare (
        .clk     (clk),
        .rst     (rst),
        .stage_i (stage),
        .phase_i (phase),
        .duty_i  (duty),
        .pwm_o   (pwm_o)
    );

    // filter-enable driver, aligned with the registered PWM output
    always_ff @(posedge clk) begin
        if (rst) oe_q <= 1'b0;
        else     oe_q <= running && !slow_q;
    end

    assign filt_en_oe_o = oe_q;
    assign filt_en_o    = 1'b0;

    assert_filter_off_slow_R7: assert property (@(posedge clk) disable iff (rst)
        (running && slow_q) |=> !filt_en_oe_o);

    assert_filter_on_fast_R7: assert property (@(posedge clk) disable iff (rst)
        (running && !slow_q) |=> filt_en_oe_o);

endmodule

// File: tb/dual_mode_pwm_bench.sv
module dual_mode_pwm_bench;

    localparam int DW  = 4;
    localparam int PL  = 1;
    localparam int FL  = 6;
    localparam int SW  = $clog2(FL + 1);
    localparam int FP  = 1 << DW;
    localparam int PS  = 1 << PL;
    localparam int BP  = FP * PS;
    localparam int FR  = BP * FL;
    localparam int MAXD = FP - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          slow_mode = 1'b0;
    logic [DW-1:0] fast_duty = '0;
    logic [SW-1:0] slow_full = '0;
    logic [DW-1:0] slow_part = '0;
    logic          pwm, oe, fen;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    dual_mode_pwm #(
        .DUTY_W        (DW),
        .PRESCALE_LOG2 (PL),
        .FRAME_LEN     (FL)
    ) u_dual_mode_pwm (
        .clk          (clk),
        .rst          (rst),
        .slow_mode_i  (slow_mode),
        .fast_duty_i  (fast_duty),
        .slow_full_i  (slow_full),
        .slow_part_i  (slow_part),
        .pwm_o        (pwm),
        .filt_en_oe_o (oe),
        .filt_en_o    (fen)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic measure(input int n, output int hi, output int edges);
        logic prev;
        prev  = pwm;
        hi    = 0;
        edges = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm) hi++;
            if (pwm && !prev) edges++;
            prev = pwm;
        end
    endtask

    task automatic wait_rise();
        logic prev;
        prev = pwm;
        for (int i = 0; i < 4 * FR; i++) begin
            @(negedge clk);
            if (pwm && !prev) return;
            prev = pwm;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
        finish_run();
    end

    initial begin
        int hi, edges, exp_hi, exp_e, full_eff;

        // R8: reset state
        fast_duty = 4'd8;
        repeat (3) @(negedge clk);
        check(pwm == 1'b0, "R8 pwm in reset", pwm, 0);
        check(oe == 1'b0,  "R8 oe in reset", oe, 0);
        rst = 1'b0;
        @(negedge clk);
        check(pwm == 1'b0, "R8 load cycle pwm", pwm, 0);
        check(oe == 1'b0,  "R8 load cycle oe", oe, 0);
        @(negedge clk);
        check(pwm == 1'b1, "R8 first period starts", pwm, 1);
        check(oe == 1'b1 && fen == 1'b0, "R7 fast oe driven low", oe, 1);
        hi = 1;
        for (int i = 1; i < FP; i++) begin
            @(negedge clk);
            if (pwm) hi++;
        end
        check(hi == 8, "R1 first period high count", hi, 8);

        // R1 R4 R5: fast sweep
        for (int d = 0; d < FP; d++) begin
            fast_duty = DW'(d);
            repeat (3 * FP) @(negedge clk);
            measure(4 * FP, hi, edges);
            exp_hi = (d == MAXD) ? FP : d;
            exp_e  = (exp_hi == 0 || exp_hi == FP) ? 0 : 4;
            check(hi == 4 * exp_hi, "R1 fast high count", hi, 4 * exp_hi);
            check(edges == exp_e, (d == 0) ? "R5 fast zero edges" :
                                  (d == MAXD) ? "R4 fast full edges" : "R1 fast edges",
                  edges, exp_e);
        end

        // R6: duty change mid-period keeps current period
        fast_duty = 4'd12;
        repeat (3 * FP) @(negedge clk);
        wait_rise();
        hi = 1;
        for (int i = 1; i < FP; i++) begin
            @(negedge clk);
            if (pwm) hi++;
            if (i == 5) fast_duty = 4'd3;
        end
        check(hi == 12, "R6 current period unchanged", hi, 12);
        measure(FP, hi, edges);
        check(hi == 3, "R6 next period uses new duty", hi, 3);

        // R7: mode change waits for the period boundary
        wait_rise();
        slow_mode = 1'b1;
        slow_full = 3'd2;
        slow_part = 4'd0;
        @(negedge clk);
        check(oe == 1'b1, "R7 oe holds until boundary", oe, 1);
        repeat (FP + 2) @(negedge clk);
        check(oe == 1'b0, "R7 oe released in slow", oe, 0);

        // R2 R3 R4 R5: slow sweep
        for (int f = 0; f <= FL + 1; f++) begin
            for (int k = 0; k < 4; k++) begin
                int p;
                p = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 9 : MAXD;
                slow_full = SW'(f);
                slow_part = DW'(p);
                repeat (2 * FR + 8) @(negedge clk);
                measure(2 * FR, hi, edges);
                full_eff = (f > FL) ? FL : f;
                if (full_eff >= FL) exp_hi = FR;
                else exp_hi = full_eff * BP + ((p == MAXD) ? BP : p * PS);
                exp_e = (exp_hi == 0 || exp_hi == FR) ? 0 : 2;
                check(hi == 2 * exp_hi, (p == MAXD) ? "R4 slow partial full" :
                                        (f == 0 && p == 0) ? "R5 slow zero" :
                                        "R3 slow frame high count", hi, 2 * exp_hi);
                check(edges == exp_e, "R2 one pulse per frame", edges, exp_e);
                check(oe == 1'b0, "R7 oe off in slow", oe, 0);
            end
        end

        // R7: back to fast re-drives the filter pin
        slow_mode = 1'b0;
        fast_duty = 4'd5;
        repeat (FR + FP + 4) @(negedge clk);
        check(oe == 1'b1 && fen == 1'b0, "R7 oe driven again in fast", oe, 1);
        measure(2 * FP, hi, edges);
        check(hi == 10, "R1 fast after slow", hi, 10);

        finish_run();
    end

endmodule